// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one serial flash command at a time from a small byte-addressed register bank. Software writes a total bit count, an opcode byte and up to five trailing transmit bytes such as address bytes. It then writes the control register with the execute bit set. The engine pulls chip select low and clocks out exactly the programmed number of bits, most significant bit first. The serial link runs in mode 0, with the clock idling low. Every bit also samples MISO into a receive register.

When the bit count runs out, the engine drives MOSI low and releases chip select. It then clears busy and sets done. The received bytes stay readable by index. The receive register keeps shifting upward for the whole transaction. For a transfer of one opcode byte followed by n data bytes:
- the byte captured during the opcode lands at index n;
- the first byte returned by the flash lands at index n-1;
- the last byte returned lands at index 0.

A mode bit in the control register makes a command take its opcode from transmit slot 3 instead of slot 5. Slots 2 to 0 then follow it.

Top module: `sfc_engine`

## Requirements
- R1: Register map, 5-bit byte address:
  - Transmit slots 0 to 5 are at 0x00 to 0x05 and read back as written.
  - The bit count is at 0x08 and the SCK divider at 0x0A; both read back.
  - Control is at 0x09: bit 0 is execute (write-only, reads 0) and bit 1 selects the alternate opcode slot (reads back).
  - Status is at 0x0B: bit 0 is busy and bit 1 is done.
  - Receive byte i is at 0x10+i, for i from 0 to 6.
- R2: SCK idles low and each SCK half period lasts divider+1 system clocks.
  - Chip select goes low in the cycle after an accepted execute.
  - The first rising SCK edge comes one half period later.
  - Chip select goes high one half period after the last falling SCK edge.
- R3: In normal mode (control bit 1 = 0), MOSI carries slot 5 (the opcode) first, then slots 4, 3, 2, 1 and 0, each byte MSB first. Bits beyond the 48 held in the slots are 0. MOSI changes only when chip select falls or SCK falls.
- R4: In alternate mode (control bit 1 = 1, taken from the same write as execute), MOSI carries slot 3 first, then slots 2, 1 and 0, MSB first. All later bits are 0.
- R5: MISO is sampled on every rising SCK edge into a 56-bit receive register that is cleared at the start of a transaction.
  - After c bits, transaction bit t (0 is the first) sits at register bit c-1-t.
  - Receive byte k is register bits 8k+7 to 8k.
  - Bits above c-1 read 0.
- R6: Busy reads 1 from the cycle after an accepted execute until chip select is released. An execute written while busy is ignored and does not disturb the running transfer.
- R7: Done is cleared by an accepted execute with a valid count and is set in the same cycle that chip select is released. It stays set until the next accepted execute.
- R8: An execute with a bit count of 0 or above 56 causes no chip select or SCK activity and sets done in the next cycle.
- R9: MOSI is 0 while chip select is high and after the last programmed bit, even when later transmit slots hold data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe for the addressed byte |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The symptom of a wrong internal state depends on which state is wrong:
- A wrong phase or half-period count shows within one half period as a misplaced SCK edge or chip select transition.
- A wrong remaining-bit count shows at the end of the transfer, when chip select rises a whole SCK period early or late.
- A wrong transmit shift-register load or shift shows on MOSI at the first bit affected.
- A wrong receive shift shows only when the receive bytes are read back after completion, as bytes that have moved or are mirrored.

The bench therefore compares SCK, chip select, MOSI and status against its reference on every cycle, and reads all seven receive bytes after every valid transfer.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_LEAD  = 3'd1,
      PH_HIGH  = 3'd2,
      PH_LOW   = 3'd3,
      PH_TRAIL = 3'd4
   } phase_t;

   localparam int ADR_TX0   = 'h00;
   localparam int ADR_COUNT = 'h08;
   localparam int ADR_CTRL  = 'h09;
   localparam int ADR_DIV   = 'h0A;
   localparam int ADR_STAT  = 'h0B;
   localparam int ADR_RX0   = 'h10;

   localparam int CTRL_GO  = 0;
   localparam int CTRL_ALT = 1;

endpackage

// File: rtl/sfc_halfdiv.sv
module sfc_halfdiv #(
   parameter int DIVW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [DIVW-1:0] half_m1,
   output logic            tick
);

   logic [DIVW-1:0] cnt_q;

   assign tick = run && (cnt_q == half_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + DIVW'(1);
      end
   end

endmodule

// File: rtl/sfc_txshift.sv
module sfc_txshift #(
   parameter int SHW      = 56,
   parameter int NSLOTS   = 6,
   parameter int ALT_SLOT = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                alt,
   input  logic                shift,
   input  logic [8*NSLOTS-1:0] slots,
   output logic                msb
);

   localparam int NPAD = SHW - 8*NSLOTS;
   localparam int APAD = SHW - 8*(ALT_SLOT+1);

   logic [SHW-1:0] sh_q;
   logic [SHW-1:0] norm_vec;
   logic [SHW-1:0] alt_vec;

   assign norm_vec = {slots, {NPAD{1'b0}}};
   assign alt_vec  = {slots[8*ALT_SLOT+7:0], {APAD{1'b0}}};
   assign msb      = sh_q[SHW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= alt ? alt_vec : norm_vec;
      end else if (shift) begin
         sh_q <= {sh_q[SHW-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/sfc_rxshift.sv
module sfc_rxshift #(
   parameter int SHW = 56
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           sample,
   input  logic           din,
   output logic [SHW-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clear) begin
         q <= '0;
      end else if (sample) begin
         q <= {q[SHW-2:0], din};
      end
   end

endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
   import sfc_pkg::*;
#(
   parameter int NSLOTS   = 6,
   parameter int RXBYTES  = 7,
   parameter int ALT_SLOT = 3,
   parameter int DIVW     = 8,
   parameter int AW       = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [AW-1:0] reg_addr,
   input  logic [7:0]    reg_wdata,
   output logic [7:0]    reg_rdata,
   output logic          spi_sck,
   output logic          spi_cs_n,
   output logic          spi_mosi,
   input  logic          spi_miso
);

   localparam int MAXBITS = 8*RXBYTES;
   localparam int CW      = $clog2(MAXBITS+1);

   generate
      if (ALT_SLOT >= NSLOTS) begin : g_bad_alt
         $error("ALT_SLOT must name an existing transmit slot");
      end
      if (RXBYTES <= NSLOTS) begin : g_bad_rx
         $error("receive window must exceed the transmit slots");
      end
      if (MAXBITS > 255) begin : g_bad_max
         $error("bit count register is eight bits wide");
      end
      if (DIVW > 8) begin : g_bad_div
         $error("divider must fit one register byte");
      end
      if (ADR_RX0 + RXBYTES > (1 << AW)) begin : g_bad_aw
         $error("address width too small for receive bytes");
      end
   endgenerate

   logic [8*NSLOTS-1:0] tx_slots;
   logic [7:0]          count_q;
   logic [DIVW-1:0]     div_q;
   logic                alt_q;
   logic                done_q;
   phase_t              phase;
   logic [CW-1:0]       left_q;
   logic                sck_q;
   logic                cs_n_q;
   logic                tick;
   logic                tx_msb;
   logic [MAXBITS-1:0]  rx_q;
   logic [7:0]          rx_bytes [RXBYTES];

   logic ctrl_wr, exec, busy, accept, cnt_ok, start, shifting;

   assign ctrl_wr = reg_wr && (reg_addr == AW'(ADR_CTRL));
   assign exec    = ctrl_wr && reg_wdata[CTRL_GO];
   assign busy    = (phase != PH_IDLE);
   assign accept  = exec && !busy;
   assign cnt_ok  = (count_q != 8'd0) && (count_q <= 8'(MAXBITS));
   assign start   = accept && cnt_ok;
   assign shifting = (phase == PH_LEAD) || (phase == PH_HIGH) || (phase == PH_LOW);

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_slots <= '0;
         count_q  <= '0;
         div_q    <= '0;
         alt_q    <= 1'b0;
      end else if (reg_wr) begin
         for (int i = 0; i < NSLOTS; i++) begin
            if (reg_addr == AW'(ADR_TX0 + i)) tx_slots[8*i +: 8] <= reg_wdata;
         end
         if (reg_addr == AW'(ADR_COUNT)) count_q <= reg_wdata;
         if (reg_addr == AW'(ADR_DIV))   div_q   <= reg_wdata[DIVW-1:0];
         if (ctrl_wr)                    alt_q   <= reg_wdata[CTRL_ALT];
      end
   end

   // transaction sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         sck_q  <= 1'b0;
         cs_n_q <= 1'b1;
         done_q <= 1'b0;
         left_q <= '0;
      end else begin
         case (phase)
            PH_IDLE: if (accept) begin
               done_q <= !cnt_ok;
               if (cnt_ok) begin
                  phase  <= PH_LEAD;
                  cs_n_q <= 1'b0;
                  left_q <= CW'(count_q);
               end
            end
            PH_LEAD: if (tick) begin
               sck_q <= 1'b1;
               phase <= PH_HIGH;
            end
            PH_HIGH: if (tick) begin
               sck_q  <= 1'b0;
               left_q <= left_q - CW'(1);
               phase  <= (left_q == CW'(1)) ? PH_TRAIL : PH_LOW;
            end
            PH_LOW: if (tick) begin
               sck_q <= 1'b1;
               phase <= PH_HIGH;
            end
            PH_TRAIL: if (tick) begin
               cs_n_q <= 1'b1;
               done_q <= 1'b1;
               phase  <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   sfc_halfdiv #(.DIVW(DIVW)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .half_m1(div_q), .tick(tick)
   );

   sfc_txshift #(.SHW(MAXBITS), .NSLOTS(NSLOTS), .ALT_SLOT(ALT_SLOT)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(start), .alt(reg_wdata[CTRL_ALT]),
      .shift(tick && (phase == PH_HIGH)), .slots(tx_slots), .msb(tx_msb)
   );

   sfc_rxshift #(.SHW(MAXBITS)) u_rx (
      .clk(clk), .rst_n(rst_n), .clear(start),
      .sample(tick && ((phase == PH_LEAD) || (phase == PH_LOW))),
      .din(spi_miso), .q(rx_q)
   );

   generate
      for (genvar g = 0; g < RXBYTES; g++) begin : g_rxb
         assign rx_bytes[g] = rx_q[8*g +: 8];
      end
   endgenerate

   assign spi_sck  = sck_q;
   assign spi_cs_n = cs_n_q;
   assign spi_mosi = shifting && tx_msb;

   always_comb begin
      reg_rdata = 8'd0;
      for (int i = 0; i < NSLOTS; i++) begin
         if (reg_addr == AW'(ADR_TX0 + i)) reg_rdata = tx_slots[8*i +: 8];
      end
      for (int i = 0; i < RXBYTES; i++) begin
         if (reg_addr == AW'(ADR_RX0 + i)) reg_rdata = rx_bytes[i];
      end
      if (reg_addr == AW'(ADR_COUNT)) reg_rdata = count_q;
      if (reg_addr == AW'(ADR_CTRL))  reg_rdata = {6'd0, alt_q, 1'b0};
      if (reg_addr == AW'(ADR_DIV))   reg_rdata = 8'(div_q);
      if (reg_addr == AW'(ADR_STAT))  reg_rdata = {6'd0, done_q, busy};
   end

endmodule

// File: rtl/sfc_engine_chk.sv
module sfc_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic sck,
   input logic cs_n,
   input logic mosi,
   input logic busy,
   input logic done,
   input logic exec_req
);

   // R2
   idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   // R9
   idle_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !mosi);

   // R6
   busy_tracks_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !cs_n);

   // R6
   cs_fall_needs_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> ($past(exec_req) && !$past(busy)));

   // R7
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R7
   done_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(exec_req) || $rose(cs_n)));

   // R3
   mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(cs_n) && !$fell(sck)) |-> $stable(mosi));

endmodule

bind sfc_engine sfc_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n), .mosi(spi_mosi),
   .busy(busy), .done(done_q), .exec_req(exec)
);

// File: tb/sfc_engine_bench.sv
`timescale 1ns/1ps
module sfc_engine_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [4:0] reg_addr = 5'h0B;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       spi_sck, spi_cs_n, spi_mosi, spi_miso;

   always #2.5 clk = ~clk;

   sfc_engine u_sfc_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   int vectors = 0;
   int errors  = 0;
   bit finished = 0;

   logic [7:0] sh_slot [6];
   int         sh_count = 0;
   int         sh_div   = 0;
   bit         sh_alt   = 0;

   bit          m_busy = 0, m_done = 0;
   int          m_j = 0, m_c = 0, m_h = 1;
   logic [55:0] m_tx = '0;

   logic [55:0] pat = '0;
   int          fcnt = 0;

   // flash side: next bit after each falling SCK, restart on deselect
   always @(negedge spi_sck or posedge spi_cs_n) begin
      if (spi_cs_n) fcnt <= 0;
      else          fcnt <= fcnt + 1;
   end
   assign spi_miso = (fcnt < 56) ? pat[55-fcnt] : 1'b0;

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [55:0] tx_vector(bit alt);
      if (alt) return {sh_slot[3], sh_slot[2], sh_slot[1], sh_slot[0], 24'd0};
      return {sh_slot[5], sh_slot[4], sh_slot[3], sh_slot[2], sh_slot[1], sh_slot[0], 8'd0};
   endfunction

   // reference model, advanced on each clock
   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_j = 0;
      end else if (m_busy) begin
         m_j++;
         if (m_j == (2*m_c + 1)*m_h) begin
            m_busy = 0; m_done = 1;
         end
      end else if (reg_wr && reg_addr == 5'h09 && reg_wdata[0]) begin
         if (sh_count >= 1 && sh_count <= 56) begin
            m_busy = 1; m_done = 0; m_j = 0;
            m_c = sh_count; m_h = sh_div + 1; m_tx = tx_vector(sh_alt);
         end else begin
            m_done = 1;
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         bit e_sck, e_mosi;
         int k;
         e_sck = 0; e_mosi = 0;
         if (m_busy) begin
            k = m_j / m_h;
            if (k < 2*m_c) begin
               e_sck  = k[0];
               e_mosi = m_tx[55 - k/2];
            end
         end
         check("R2 sck",     {7'd0, spi_sck},  {7'd0, e_sck});
         check("R6 cs_n",    {7'd0, spi_cs_n}, {7'd0, !m_busy});
         check("R3/R4/R9 mosi", {7'd0, spi_mosi}, {7'd0, e_mosi});
         if (reg_addr == 5'h0B)
            check("R6/R7 status", reg_rdata, {6'd0, m_done, m_busy});
      end
   end

   task automatic wr(logic [4:0] a, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      if (a <= 5'h05) sh_slot[a] = d;
      if (a == 5'h08) sh_count = d;
      if (a == 5'h0A) sh_div = d;
      if (a == 5'h09) sh_alt = d[1];
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 5'h0B; reg_wdata = 8'd0;
   endtask

   task automatic rd_check(string req, logic [4:0] a, logic [7:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 check(req, reg_rdata, exp);
      @(negedge clk);
      reg_addr = 5'h0B;
   endtask

   task automatic wait_idle();
      while (m_busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic rx_check(int c);
      logic [55:0] e;
      e = pat >> (56 - c);
      for (int i = 0; i < 7; i++) rd_check("R5 rx byte", 5'(16 + i), e[8*i +: 8]);
   endtask

   task automatic run(int c, int dv, bit alt, logic [55:0] p);
      pat = p;
      wr(5'h08, 8'(c));
      wr(5'h0A, 8'(dv));
      wr(5'h09, {6'd0, alt, 1'b1});
      wait_idle();
   endtask

   initial begin
      for (int i = 0; i < 6; i++) sh_slot[i] = 8'd0;
      repeat (3) @(negedge clk);
      #1 check("R2 reset cs_n", {7'd0, spi_cs_n}, 8'd1);
      check("R7 reset status", reg_rdata, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 register readback
      wr(5'h05, 8'h9F); wr(5'h04, 8'h12); wr(5'h03, 8'hA5);
      wr(5'h02, 8'h3C); wr(5'h01, 8'hC3); wr(5'h00, 8'h5A);
      rd_check("R1 slot3", 5'h03, 8'hA5);
      rd_check("R1 slot0", 5'h00, 8'h5A);
      wr(5'h08, 8'd40); wr(5'h0A, 8'd2); wr(5'h09, 8'h02);
      rd_check("R1 count", 5'h08, 8'd40);
      rd_check("R1 div", 5'h0A, 8'd2);
      rd_check("R1 ctrl", 5'h09, 8'h02);

      // R3 normal mode, fastest clock, opcode plus three receive bytes
      run(32, 0, 0, 56'hDE_AD_BE_EF_01_23_45);
      rx_check(32);
      // R5 full window, slower clock
      run(56, 2, 0, 56'h81_42_24_18_FF_00_6B);
      rx_check(56);
      // R4 alternate opcode slot
      run(40, 1, 1, 56'h0F_F0_33_CC_55_AA_77);
      rx_check(40);
      // R5 count not a byte multiple
      run(13, 0, 0, 56'hB7_3E_00_00_00_00_00);
      rx_check(13);
      // R9 only the opcode clocked though later slots hold data
      run(8, 3, 0, 56'h11_22_33_44_55_66_77);
      rx_check(8);

      // R6 execute while busy is ignored
      pat = 56'hC0_FF_EE_00_11_22_33;
      wr(5'h08, 8'd16); wr(5'h0A, 8'd3); wr(5'h09, 8'h01);
      repeat (6) @(negedge clk);
      wr(5'h08, 8'd48);
      wr(5'h09, 8'h01);
      wait_idle();
      rx_check(16);

      // R8 invalid counts
      wr(5'h08, 8'd0); wr(5'h09, 8'h01);
      repeat (4) @(negedge clk);
      #1 check("R8 zero count done", reg_rdata, 8'h02);
      check("R8 zero count cs_n", {7'd0, spi_cs_n}, 8'd1);
      run(24, 0, 0, 56'h12_34_56_00_00_00_00);
      wr(5'h08, 8'd57); wr(5'h09, 8'h01);
      repeat (4) @(negedge clk);
      #1 check("R8 oversize done", reg_rdata, 8'h02);
      check("R8 oversize cs_n", {7'd0, spi_cs_n}, 8'd1);

      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         finished = 1;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

endmodule